// File: doc/BRIEF.md
# Delay-Line Sampling Phase Tuner

This block tunes the sampling point of a receiver that captures data through a tapped delay line. After a start pulse, it first calibrates the line. It raises the per-tap unit delay one step at a time. At each step it waits for a measured length word and accepts the first step whose length pattern shows that the whole line spans less than one clock period. The highest set bit of the accepted length gives the last usable tap.

The tuner then programs each tap from 0 up to that last tap in turn. For each tap it asks an external agent to run one test transfer and records whether the transfer passed. From the longest unbroken run of passing taps it picks the centre and programs that tap. It finishes with a one-cycle done pulse that carries the chosen tap and unit. If tuning fails, it instead gives a one-cycle error pulse with a code.

The delay line is outside the block. The tuner drives its unit, tap-select, configuration-write and sampler-enable lines, and reads back its length word and length-valid flag.

The controller has these states:

| State | Behaviour and transitions |
|---|---|
| `ST_IDLE` | Waits for `start`, then goes to `ST_CAL_SET`. A `start` pulse outside this state is ignored. |
| `ST_CAL_SET` | Writes the current unit with the calibration tap code. Goes to `ST_CAL_WAIT`. |
| `ST_CAL_WAIT` | A valid length that qualifies goes to `ST_PH_SET`. A length that does not qualify, or an expired wait, moves to the next unit in `ST_CAL_SET`. After the last unit it goes to `ST_FAIL` instead. |
| `ST_PH_SET` | Writes the current tap. Goes to `ST_PH_TEST`. |
| `ST_PH_TEST` | Holds the test request until it is acknowledged. After the last tap it goes to `ST_PH_EVAL`; otherwise it returns to `ST_PH_SET` with the next tap. |
| `ST_PH_EVAL` | Goes to `ST_FAIL` if no tap passed; otherwise to `ST_FIN_SET`. |
| `ST_FIN_SET` | Writes the centre tap. Goes to `ST_DONE`. |
| `ST_DONE` | Gives the done pulse. Goes to `ST_IDLE`. |
| `ST_FAIL` | Gives the error pulse. Goes to `ST_IDLE`. |

Top module: `dlytune_ctrl`

## Requirements
- R1: After reset, `done`, `err`, `test_req`, `line_cfg_wr` and `line_sample_en` are all low and the block waits for `start`.
- R2: Each calibration step gives a one-cycle `line_cfg_wr` with `line_sel` = NTAPS+1 (12), `line_sample_en` high and `line_unit` equal to the step index. The steps start at 0 and rise by one.
- R3: Calibration accepts the first unit whose valid length is nonzero and below 2^NTAPS (2^11). A length of 0, or of 2^11 or more, moves on to the next unit.
- R4: A unit is skipped when `line_len_valid` stays low for TIMEOUT waiting cycles. A valid length that arrives in the TIMEOUT-th waiting cycle is still accepted.
- R5: If no unit up to 2^UNIT_W-1 (127) qualifies, `err` pulses with `err_code` = 1.
- R6: The last tap equals the bit index of the accepted length's highest set bit. Taps 0 to that last tap are each tested exactly once, in ascending order.
- R7: Each tap is written with `line_cfg_wr` and `line_sample_en` high. `line_sample_en` is low while `test_req` is high, and `test_req` stays high until `test_ack`.
- R8: A failed test ends the current run of passing taps. A new longest run replaces the recorded one only if it is strictly longer, so of two equal runs the earlier one wins.
- R9: The chosen tap equals the last tap of the longest run minus half the run length, rounded down. It is written with `line_cfg_wr`; then `done` pulses with `done_phase` and `done_unit`, and `line_sel` keeps the chosen tap afterwards.
- R10: If no tested tap passes, `err` pulses with `err_code` = 2.
- R11: `done` and `err` are single-cycle pulses and are never high together. `err_code` is 0 whenever `err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a tuning run when idle |
| line_len | input | LEN_W (12) | Length pattern measured by the delay line |
| line_len_valid | input | 1 | Qualifies `line_len` |
| test_ack | input | 1 | Test transfer finished; `test_pass` is valid |
| test_pass | input | 1 | Result of the test transfer |
| line_unit | output | UNIT_W (7) | Unit-delay setting for the delay line |
| line_sel | output | SEL_W (4) | Tap selection; NTAPS+1 during calibration |
| line_cfg_wr | output | 1 | One-cycle configuration write strobe |
| line_sample_en | output | 1 | Sampler enable, high around configuration writes |
| test_req | output | 1 | Request for one test transfer |
| done | output | 1 | One-cycle success pulse |
| done_unit | output | UNIT_W (7) | Calibrated unit, valid with `done` |
| done_phase | output | SEL_W (4) | Chosen tap, valid with `done` |
| err | output | 1 | One-cycle failure pulse |
| err_code | output | 2 | 1 = no unit qualified, 2 = no tap passed |

## Verification
Two events can land in the same cycle: the arrival of a length word and the expiry of the calibration wait. In that case the length word must win.

The bench provokes the collision by setting the delay-line model's latency so that the valid flag rises exactly in the TIMEOUT-th waiting cycle. That run must calibrate at unit 0 and give the expected centre tap.

With a latency one cycle longer, every unit must time out, and the run must end with error code 1 after 128 calibration writes.

// File: rtl/dlytune_pkg.sv
package dlytune_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_CAL_SET  = 4'd1,
        ST_CAL_WAIT = 4'd2,
        ST_PH_SET   = 4'd3,
        ST_PH_TEST  = 4'd4,
        ST_PH_EVAL  = 4'd5,
        ST_FIN_SET  = 4'd6,
        ST_DONE     = 4'd7,
        ST_FAIL     = 4'd8
    } tune_state_e;

    localparam logic [1:0] ERR_NONE    = 2'd0;
    localparam logic [1:0] ERR_NO_UNIT = 2'd1;
    localparam logic [1:0] ERR_NO_PASS = 2'd2;

endpackage

// File: rtl/dlytune_msb.sv
module dlytune_msb #(
    parameter int W  = 11,
    parameter int IW = 4
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dlytune_timer.sv
module dlytune_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/dlytune_window.sv
module dlytune_window #(
    parameter int SEL_W = 4,
    parameter int RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             upd,
    input  logic             pass,
    input  logic [SEL_W-1:0] phase,
    output logic [RUN_W-1:0] best_len,
    output logic [SEL_W-1:0] best_end
);
    logic [RUN_W-1:0] cur_q;
    logic [RUN_W-1:0] cur_inc;

    assign cur_inc = cur_q + RUN_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cur_q    <= '0;
            best_len <= '0;
            best_end <= '0;
        end else if (upd) begin
            if (!pass) begin
                cur_q <= '0;
            end else begin
                cur_q <= cur_inc;
                if (cur_inc > best_len) begin
                    best_len <= cur_inc;
                    best_end <= phase;
                end
            end
        end
    end
endmodule

// File: rtl/dlytune_ctrl.sv
module dlytune_ctrl
    import dlytune_pkg::*;
#(
    parameter int UNIT_W  = 7,
    parameter int SEL_W   = 4,
    parameter int LEN_W   = 12,
    parameter int NTAPS   = 11,
    parameter int TIMEOUT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  line_len,
    input  logic              line_len_valid,
    input  logic              test_ack,
    input  logic              test_pass,
    output logic [UNIT_W-1:0] line_unit,
    output logic [SEL_W-1:0]  line_sel,
    output logic              line_cfg_wr,
    output logic              line_sample_en,
    output logic              test_req,
    output logic              done,
    output logic [UNIT_W-1:0] done_unit,
    output logic [SEL_W-1:0]  done_phase,
    output logic              err,
    output logic [1:0]        err_code
);
    localparam int RUN_W = $clog2(NTAPS + 1);
    localparam logic [SEL_W-1:0]  CAL_SEL   = SEL_W'(NTAPS + 1);
    localparam logic [UNIT_W-1:0] UNIT_LAST = {UNIT_W{1'b1}};
    localparam logic [LEN_W-1:0]  LEN_LIMIT = LEN_W'(1) << NTAPS;

    tune_state_e state_q, state_d;
    logic [UNIT_W-1:0] unit_q, unit_d;
    logic [SEL_W-1:0]  phase_q, phase_d;
    logic [SEL_W-1:0]  max_q, max_d;
    logic [1:0]        code_q, code_d;

    logic              tmr_expired;
    logic              len_ok;
    logic [SEL_W-1:0]  len_msb;
    logic              win_upd;
    logic [RUN_W-1:0]  best_len;
    logic [SEL_W-1:0]  best_end;

    assign len_ok = (line_len != '0) && (line_len < LEN_LIMIT);

    dlytune_msb #(.W(NTAPS), .IW(SEL_W)) u_msb (
        .vec (line_len[NTAPS-1:0]),
        .idx (len_msb)
    );

    dlytune_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_CAL_WAIT),
        .expired (tmr_expired)
    );

    dlytune_window #(.SEL_W(SEL_W), .RUN_W(RUN_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q == ST_IDLE),
        .upd      (win_upd),
        .pass     (test_pass),
        .phase    (phase_q),
        .best_len (best_len),
        .best_end (best_end)
    );

    // State and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            unit_q  <= '0;
            phase_q <= '0;
            max_q   <= '0;
            code_q  <= ERR_NONE;
        end else begin
            state_q <= state_d;
            unit_q  <= unit_d;
            phase_q <= phase_d;
            max_q   <= max_d;
            code_q  <= code_d;
        end
    end

    // Next state and datapath updates
    always_comb begin
        state_d = state_q;
        unit_d  = unit_q;
        phase_d = phase_q;
        max_d   = max_q;
        code_d  = code_q;
        win_upd = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unit_d  = '0;
                    code_d  = ERR_NONE;
                    state_d = ST_CAL_SET;
                end
            end
            ST_CAL_SET: state_d = ST_CAL_WAIT;
            ST_CAL_WAIT: begin
                if (line_len_valid && len_ok) begin
                    max_d   = len_msb;
                    phase_d = '0;
                    state_d = ST_PH_SET;
                end else if (line_len_valid || tmr_expired) begin
                    if (unit_q == UNIT_LAST) begin
                        code_d  = ERR_NO_UNIT;
                        state_d = ST_FAIL;
                    end else begin
                        unit_d  = unit_q + UNIT_W'(1);
                        state_d = ST_CAL_SET;
                    end
                end
            end
            ST_PH_SET: state_d = ST_PH_TEST;
            ST_PH_TEST: begin
                if (test_ack) begin
                    win_upd = 1'b1;
                    if (phase_q == max_q) begin
                        state_d = ST_PH_EVAL;
                    end else begin
                        phase_d = phase_q + SEL_W'(1);
                        state_d = ST_PH_SET;
                    end
                end
            end
            ST_PH_EVAL: begin
                if (best_len == '0) begin
                    code_d  = ERR_NO_PASS;
                    state_d = ST_FAIL;
                end else begin
                    phase_d = best_end - SEL_W'(best_len >> 1);
                    state_d = ST_FIN_SET;
                end
            end
            ST_FIN_SET: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            ST_FAIL:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        line_unit      = unit_q;
        line_sel       = phase_q;
        line_cfg_wr    = 1'b0;
        line_sample_en = 1'b0;
        test_req       = 1'b0;
        done           = 1'b0;
        done_unit      = '0;
        done_phase     = '0;
        err            = 1'b0;
        err_code       = ERR_NONE;
        unique case (state_q)
            ST_CAL_SET: begin
                line_sel       = CAL_SEL;
                line_cfg_wr    = 1'b1;
                line_sample_en = 1'b1;
            end
            ST_CAL_WAIT: begin
                line_sel       = CAL_SEL;
                line_sample_en = 1'b1;
            end
            ST_PH_SET, ST_FIN_SET: begin
                line_cfg_wr    = 1'b1;
                line_sample_en = 1'b1;
            end
            ST_PH_TEST: test_req = 1'b1;
            ST_DONE: begin
                done       = 1'b1;
                done_unit  = unit_q;
                done_phase = phase_q;
            end
            ST_FAIL: begin
                err      = 1'b1;
                err_code = code_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dlytune_chk.sv
module dlytune_chk #(
    parameter int SEL_W = 4,
    parameter int NTAPS = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] line_sel,
    input logic             line_cfg_wr,
    input logic             line_sample_en,
    input logic             test_req,
    input logic             test_ack,
    input logic             done,
    input logic [SEL_W-1:0] done_phase,
    input logic             err,
    input logic [1:0]       err_code
);
    localparam logic [SEL_W-1:0] CAL_SEL = SEL_W'(NTAPS + 1);

    a_r2_cal_write_sampler: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cfg_wr && line_sel == CAL_SEL) |-> line_sample_en);

    a_r6_test_tap_range: assert property (@(posedge clk) disable iff (!rst_n)
        test_req |-> (line_sel < SEL_W'(NTAPS)));

    a_r7_test_sampler_off: assert property (@(posedge clk) disable iff (!rst_n)
        test_req |-> !line_sample_en);

    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req && !test_ack) |=> test_req);

    a_r9_done_tap_driven: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (line_sel == done_phase));

    a_r9_final_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(line_cfg_wr));

    a_r10_err_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code == 2'd1 || err_code == 2'd2));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    a_r11_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !err |-> (err_code == 2'd0));
endmodule

bind dlytune_ctrl dlytune_chk #(.SEL_W(SEL_W), .NTAPS(NTAPS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_sel       (line_sel),
    .line_cfg_wr    (line_cfg_wr),
    .line_sample_en (line_sample_en),
    .test_req       (test_req),
    .test_ack       (test_ack),
    .done           (done),
    .done_phase     (done_phase),
    .err            (err),
    .err_code       (err_code)
);

// File: tb/dlytune_ctrl_tb.sv
module dlytune_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 32;

    typedef struct packed {
        logic [7:0]  first;    // first qualifying unit, 128 = none
        logic        silent;   // units below first give no valid flag
        logic [11:0] bad_len;
        logic [11:0] good_len;
        logic [15:0] mask;     // pass result per tap
        logic [1:0]  code;
        logic [6:0]  unit;
        logic [3:0]  phase;
        logic [4:0]  ntest;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{8'd0,   1'b0, 12'h000, 12'h07F, 16'h007C, 2'd0, 7'd0, 4'd4, 5'd7},
        '{8'd3,   1'b0, 12'hFFF, 12'h3FF, 16'h01E6, 2'd0, 7'd3, 4'd6, 5'd10},
        '{8'd2,   1'b0, 12'h000, 12'h400, 16'h0033, 2'd0, 7'd2, 4'd0, 5'd11},
        '{8'd1,   1'b0, 12'h800, 12'h001, 16'h0001, 2'd0, 7'd1, 4'd0, 5'd1},
        '{8'd0,   1'b0, 12'h000, 12'h00F, 16'h0000, 2'd2, 7'd0, 4'd0, 5'd4},
        '{8'd128, 1'b0, 12'hFFF, 12'h001, 16'hFFFF, 2'd1, 7'd0, 4'd0, 5'd0},
        '{8'd4,   1'b1, 12'h000, 12'h1FF, 16'h01FF, 2'd0, 7'd4, 4'd4, 5'd9},
        '{8'd0,   1'b0, 12'h000, 12'h007, 16'hFFF8, 2'd2, 7'd0, 4'd0, 5'd3},
        '{8'd0,   1'b0, 12'h000, 12'h0FF, 16'h00C0, 2'd0, 7'd0, 4'd6, 5'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] line_len;
    logic        line_len_valid;
    logic        test_ack;
    logic        test_pass;
    logic [6:0]  line_unit;
    logic [3:0]  line_sel;
    logic        line_cfg_wr;
    logic        line_sample_en;
    logic        test_req;
    logic        done;
    logic [6:0]  done_unit;
    logic [3:0]  done_phase;
    logic        err;
    logic [1:0]  err_code;

    int checks = 0;
    int failures = 0;
    vec_t cur = VECS[0];
    int lat = 2;
    int vcnt = 0;
    int cal_writes = 0, unit_err = 0, ph_count = 0, sel_err = 0, samp_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dlytune_ctrl #(.TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .line_len(line_len), .line_len_valid(line_len_valid),
        .test_ack(test_ack), .test_pass(test_pass),
        .line_unit(line_unit), .line_sel(line_sel), .line_cfg_wr(line_cfg_wr),
        .line_sample_en(line_sample_en), .test_req(test_req),
        .done(done), .done_unit(done_unit), .done_phase(done_phase),
        .err(err), .err_code(err_code)
    );

    // Delay-line model
    logic below_first;
    logic respond;
    assign below_first = ({1'b0, line_unit} < cur.first);
    assign respond     = (line_sel == 4'd12) && !(cur.silent && below_first);
    assign line_len    = below_first ? cur.bad_len : cur.good_len;

    always @(posedge clk) begin
        if (!rst_n || line_cfg_wr) begin
            vcnt           <= 0;
            line_len_valid <= 1'b0;
        end else begin
            if (vcnt < 100000) vcnt <= vcnt + 1;
            line_len_valid <= respond && (vcnt >= lat - 1);
        end
    end

    // Test-transfer responder
    always @(posedge clk) begin
        if (!rst_n) begin
            test_ack  <= 1'b0;
            test_pass <= 1'b0;
        end else if (test_req && !test_ack) begin
            test_ack  <= 1'b1;
            test_pass <= cur.mask[line_sel];
        end else begin
            test_ack <= 1'b0;
        end
    end

    // Monitor of configuration writes and tests
    always @(negedge clk) begin
        if (rst_n && line_cfg_wr && line_sel == 4'd12) begin
            if (int'(line_unit) != cal_writes) unit_err++;
            if (!line_sample_en) samp_err++;
            cal_writes++;
        end
        if (rst_n && line_cfg_wr && !line_sample_en) samp_err++;
        if (rst_n && test_req && test_ack) begin
            if (int'(line_sel) != ph_count) sel_err++;
            if (line_sample_en) samp_err++;
            ph_count++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int lat_i, input int exp_cal,
                           input string name);
        int n;
        bit got_done, got_err;
        logic [1:0] r_code;
        logic [6:0] r_unit;
        logic [3:0] r_phase;
        cur = v;
        lat = lat_i;
        cal_writes = 0; unit_err = 0; ph_count = 0; sel_err = 0; samp_err = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!done && !err && n < 30000) begin
            @(negedge clk);
            n++;
        end
        got_done = done; got_err = err;
        r_code = err_code; r_unit = done_unit; r_phase = done_phase;
        @(negedge clk);
        $display("run %s", name);
        check(!done && !err, "R11", "pulse is single cycle", int'(done || err), 0);
        check(unit_err == 0, "R2", "calibration unit sequence", unit_err, 0);
        check(cal_writes == exp_cal, "R3/R4 unit count", "calibration writes", cal_writes, exp_cal);
        check(ph_count == int'(v.ntest), "R6", "number of taps tested", ph_count, int'(v.ntest));
        check(sel_err == 0, "R6", "tap order", sel_err, 0);
        check(samp_err == 0, "R7", "sampler enable around writes/tests", samp_err, 0);
        if (v.code == 2'd0) begin
            check(got_done && !got_err, "R9", "done seen", int'(got_done), 1);
            check(r_unit == v.unit, "R3", "done_unit", int'(r_unit), int'(v.unit));
            check(r_phase == v.phase, "R8/R9 centre", "done_phase", int'(r_phase), int'(v.phase));
            check(line_sel == v.phase, "R9", "line_sel after done", int'(line_sel), int'(v.phase));
        end else if (v.code == 2'd1) begin
            check(got_err && r_code == 2'd1, "R5", "err_code", int'(r_code), 1);
        end else begin
            check(got_err && r_code == 2'd2, "R10", "err_code", int'(r_code), 2);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vec_t t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!done && !err && !test_req && !line_cfg_wr && !line_sample_en,
              "R1", "outputs quiet after reset",
              int'({done, err, test_req, line_cfg_wr, line_sample_en}), 0);
        repeat (3) @(negedge clk);
        check(!line_cfg_wr && !test_req, "R1", "idle without start",
              int'({line_cfg_wr, test_req}), 0);

        // Vector table walk
        for (int i = 0; i < 9; i++) begin
            run_vec(VECS[i], 2,
                    (VECS[i].first == 8'd128) ? 128 : int'(VECS[i].first) + 1,
                    $sformatf("vector %0d", i));
        end

        // R4: valid in the last waiting cycle still wins over timeout
        run_vec(VECS[0], TMO - 1, 1, "valid at timeout edge");

        // R4/R5: valid one cycle too late, every unit skipped
        t = VECS[0];
        t.code  = 2'd1;
        t.ntest = 5'd0;
        run_vec(t, TMO, 128, "valid after timeout");

        // Back-to-back rerun after a failure
        run_vec(VECS[1], 3, 4, "rerun after failure");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule